// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block determines when an external flash has finished a program or erase that something else has already issued. After a start strobe it waits for the device's ready/busy pin. If the pin stays low, it waits until a bounded number of cycles has passed. It then polls one address. Each poll step is a pair of reads taken back to back. If the toggle bit (bit 6) reads the same in both reads, the device is idle. If the toggle bit differs, the device is still busy. While it is busy, bit 5 is the device's own time-limit flag. When bit 5 is set, one confirming pair of reads separates a real device failure from an operation that finished just in time.

The block drives its own address, chip-enable and output-enable lines for these reads and takes the read data back from the flash data bus. When polling ends it raises `done` for one clock. `result` then holds success, error or timeout until the next accepted start.

The state machine has seven states. IDLE waits for start. WAIT_RB waits for the ready/busy pin. STEP samples the timeout and opens a pair of reads. RD_ON holds output-enable low. RD_OFF is the high gap between reads. JUDGE evaluates the pair. FINISH pulses done.

The transitions are:
- start: IDLE to WAIT_RB.
- go: WAIT_RB to STEP.
- open: STEP to RD_ON.
- strobe end: RD_ON to RD_OFF.
- next read: RD_OFF to RD_ON.
- pair complete: RD_OFF to JUDGE.
- settled, failed or expired: JUDGE to FINISH.
- confirm: JUDGE to RD_ON for the second pair.
- retry: JUDGE to STEP.
- release: FINISH to IDLE.

Top module: `tbp_poller`

## Requirements
- R1: After reset, `done` is 0, `result` is 0 (none), and `mem_ce_n` and `mem_oe_n` are both 1.
- R2: Each poll step makes two reads of the latched poll address. For each read, `mem_oe_n` is low for RD_CYC cycles, followed by at least one cycle high. `mem_ce_n` is low whenever `mem_oe_n` is low.
- R3: If bit 6 (mask 0x0040) is equal in both reads of a pair, polling ends with `result` = 1 (success).
- R4: If bit 6 differs and bit 5 (mask 0x0020) of the first read of the pair is clear, a new poll step begins and polling continues.
- R5: If bit 6 differs and bit 5 of the first read is set, one more pair is read. If bit 6 still differs in that pair, `result` = 2 (error). If it is equal, `result` = 1.
- R6: At the start of each step the block samples the timeout condition: the timeout value is zero, or the cycles elapsed since start exceed it. If that step's pair still toggles, `result` = 3 (timeout). This check comes before the bit-5 check. A pair that settles gives success even when the timeout has expired.
- R7: A timeout value of all ones never expires, however long polling takes.
- R8: After start, no read is made until `rdy_i` is 1 or RB_WAIT cycles have passed in the wait.
- R9: `done` is 1 for exactly one clock. `result` is cleared on an accepted start and stays stable from `done` until the next accepted start.
- R10: A start strobe while polling is in progress is ignored. The address and the progress of polling are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin polling; accepted only when idle |
| poll_addr | input | AW | Address to poll, latched at start |
| timeout | input | TW | Limit in clock ticks; 0 expires at once, all ones never expires |
| rdy_i | input | 1 | Flash ready/busy pin, 1 = ready |
| rd_data | input | DW | Flash read data |
| mem_addr | output | AW | Flash address for polling reads |
| mem_ce_n | output | 1 | Flash chip enable, active low |
| mem_oe_n | output | 1 | Flash output enable, active low |
| done | output | 1 | One-clock completion pulse |
| result | output | 2 | 0 none, 1 success, 2 error, 3 timeout |

## Verification
The bench builds the poller with an 8-bit timeout counter, RD_CYC of 2, RB_WAIT of 4 and the ready/busy wait enabled. With an 8-bit counter, a long busy period easily runs past 255 ticks. That lets the bench show that the all-ones value never expires, while a value of 254 does. The short RB_WAIT lets the bench observe a fallback wait with the pin held low within a few cycles. A flash model in the bench toggles bit 6 on each output-enable fall for a chosen number of reads and raises bit 5 from a chosen read onward. Varying these two counts reaches the success, retry, confirm-rescue and error paths.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

    typedef enum logic [1:0] {
        RES_NONE = 2'd0,
        RES_OK   = 2'd1,
        RES_ERR  = 2'd2,
        RES_TMO  = 2'd3
    } res_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WAIT_RB = 3'd1,
        ST_STEP    = 3'd2,
        ST_RD_ON   = 3'd3,
        ST_RD_OFF  = 3'd4,
        ST_JUDGE   = 3'd5,
        ST_FINISH  = 3'd6
    } st_e;

endpackage

// File: rtl/tbp_tick_timer.sv
module tbp_tick_timer #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    localparam logic [TW-1:0] NEVER = {TW{1'b1}};

    logic [TW-1:0] ticks_q;

    // saturating count of cycles since the accepted start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ticks_q <= '0;
        end else if (clear) begin
            ticks_q <= '0;
        end else if (run && ticks_q != NEVER) begin
            ticks_q <= ticks_q + 1'b1;
        end
    end

    always_comb begin
        if (limit == '0) begin
            expired = 1'b1;
        end else if (limit == NEVER) begin
            expired = 1'b0;
        end else begin
            expired = (ticks_q > limit);
        end
    end

endmodule

// File: rtl/tbp_rb_wait.sv
module tbp_rb_wait #(
    parameter int USE_RB  = 1,
    parameter int RB_WAIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic rdy_i,
    output logic go
);
    localparam int CW = $clog2(RB_WAIT + 1);

    generate
        if (USE_RB != 0) begin : g_pin
            logic [CW-1:0] wait_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    wait_q <= '0;
                end else if (!active) begin
                    wait_q <= '0;
                end else if (wait_q != CW'(RB_WAIT)) begin
                    wait_q <= wait_q + 1'b1;
                end
            end

            assign go = rdy_i || (wait_q == CW'(RB_WAIT));
        end else begin : g_nopin
            logic unused_rb;
            assign unused_rb = clk ^ rst_n ^ active ^ rdy_i;
            assign go = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/tbp_poller.sv
module tbp_poller
    import tbp_pkg::*;
#(
    parameter int AW       = 24,
    parameter int DW       = 16,
    parameter int TW       = 32,
    parameter int RD_CYC   = 2,
    parameter int USE_RB   = 1,
    parameter int RB_WAIT  = 16,
    parameter int TOG_BIT  = 6,
    parameter int FAIL_BIT = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] poll_addr,
    input  logic [TW-1:0] timeout,
    input  logic          rdy_i,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          done,
    output logic [1:0]    result
);
    localparam int RCW = $clog2(RD_CYC + 1);
    localparam logic [RCW-1:0] RD_LAST = RCW'(RD_CYC - 1);

    st_e            state_q, state_d;
    logic [AW-1:0]  addr_q;
    logic [TW-1:0]  limit_q;
    logic [RCW-1:0] rd_cnt_q;
    logic [1:0]     rd_idx_q;     // bit0: read within pair, bit1: confirming pair
    logic [1:0]     first_q;      // {toggle, fail} of first read in pair
    logic [1:0]     second_q;     // {toggle, fail} of second read in pair
    logic           expired_q;
    res_e           result_q;

    logic           accept;
    logic           tmr_expired;
    logic           rb_go;
    logic           toggled;
    logic           unused_rd;

    assign accept    = (state_q == ST_IDLE) && start;
    assign toggled   = first_q[1] ^ second_q[1];
    assign unused_rd = ^rd_data ^ second_q[0];

    tbp_tick_timer #(
        .TW (TW)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .run     (state_q != ST_IDLE),
        .limit   (limit_q),
        .expired (tmr_expired)
    );

    tbp_rb_wait #(
        .USE_RB  (USE_RB),
        .RB_WAIT (RB_WAIT)
    ) rbwait_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state_q == ST_WAIT_RB),
        .rdy_i  (rdy_i),
        .go     (rb_go)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_WAIT_RB;
            ST_WAIT_RB: if (rb_go) state_d = ST_STEP;
            ST_STEP:    state_d = ST_RD_ON;
            ST_RD_ON:   if (rd_cnt_q == RD_LAST) state_d = ST_RD_OFF;
            ST_RD_OFF:  state_d = rd_idx_q[0] ? ST_JUDGE : ST_RD_ON;
            ST_JUDGE: begin
                if (!toggled) begin
                    state_d = ST_FINISH;
                end else if (rd_idx_q[1]) begin
                    state_d = ST_FINISH;
                end else if (expired_q) begin
                    state_d = ST_FINISH;
                end else if (first_q[0]) begin
                    state_d = ST_RD_ON;
                end else begin
                    state_d = ST_STEP;
                end
            end
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            limit_q   <= '0;
            rd_cnt_q  <= '0;
            rd_idx_q  <= '0;
            first_q   <= '0;
            second_q  <= '0;
            expired_q <= 1'b0;
            result_q  <= RES_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        addr_q   <= poll_addr;
                        limit_q  <= timeout;
                        result_q <= RES_NONE;
                    end
                end
                ST_STEP: begin
                    expired_q <= tmr_expired;
                    rd_idx_q  <= 2'd0;
                    rd_cnt_q  <= '0;
                end
                ST_RD_ON: begin
                    rd_cnt_q <= rd_cnt_q + 1'b1;
                    if (rd_cnt_q == RD_LAST) begin
                        if (!rd_idx_q[0]) begin
                            first_q  <= {rd_data[TOG_BIT], rd_data[FAIL_BIT]};
                        end else begin
                            second_q <= {rd_data[TOG_BIT], rd_data[FAIL_BIT]};
                        end
                    end
                end
                ST_RD_OFF: begin
                    rd_cnt_q <= '0;
                    if (!rd_idx_q[0]) begin
                        rd_idx_q <= rd_idx_q + 2'd1;
                    end
                end
                ST_JUDGE: begin
                    if (!toggled) begin
                        result_q <= RES_OK;
                    end else if (rd_idx_q[1]) begin
                        result_q <= RES_ERR;
                    end else if (expired_q) begin
                        result_q <= RES_TMO;
                    end else if (first_q[0]) begin
                        rd_idx_q <= 2'd2;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_ce_n = 1'b1;
        mem_oe_n = 1'b1;
        mem_addr = '0;
        done     = 1'b0;
        unique case (state_q)
            ST_STEP, ST_RD_OFF, ST_JUDGE: begin
                mem_ce_n = 1'b0;
                mem_addr = addr_q;
            end
            ST_RD_ON: begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
                mem_addr = addr_q;
            end
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    assign result = result_q;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> $stable(result)); // R9
    AST_DONE_HAS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result != 2'd0)); // R3
    AST_OE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_ce_n); // R2
    AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R10
    AST_NO_READ_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_RB && !rb_go) |=> mem_oe_n); // R8
    AST_TMO_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 2'd3) |-> expired_q); // R6

endmodule

// File: tb/tbp_poller_tb_top.sv
module tbp_poller_tb_top;

    localparam int AW = 12;
    localparam int DW = 16;
    localparam int TW = 8;
    localparam int RD_CYC = 2;
    localparam int RB_WAIT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] poll_addr = '0;
    logic [TW-1:0] timeout = '0;
    logic          rdy_i = 1'b1;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n;
    logic          mem_oe_n;
    logic          done;
    logic [1:0]    result;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    tbp_poller #(
        .AW(AW), .DW(DW), .TW(TW), .RD_CYC(RD_CYC),
        .USE_RB(1), .RB_WAIT(RB_WAIT), .TOG_BIT(6), .FAIL_BIT(5)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .poll_addr(poll_addr),
        .timeout(timeout), .rdy_i(rdy_i), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .done(done), .result(result)
    );

    // flash status model: bit 6 flips on each oe fall for the first tog_n reads,
    // bit 5 is high from read fail_at onward (0 = never)
    logic model_clr = 1'b1;
    int   tog_n = 0;
    int   fail_at = 0;
    int   reads;
    logic dq6;
    logic dq5;
    logic oe_prev;

    always @(negedge clk) begin
        if (model_clr) begin
            reads   <= 0;
            dq6     <= 1'b0;
            oe_prev <= 1'b1;
        end else begin
            oe_prev <= mem_oe_n;
            if (oe_prev && !mem_oe_n) begin
                reads <= reads + 1;
                if (reads + 1 <= tog_n) dq6 <= ~dq6;
            end
        end
    end

    assign dq5 = (fail_at != 0) && (reads >= fail_at);
    assign rd_data = {8'h3C, 1'b0, dq6, dq5, reads[4:0]};

    // T, F, timeout, expected result, expected reads (0 = not checked)
    localparam int NV = 12;
    localparam logic [33:0] VEC [NV] = '{
        {8'd0,   8'd0, 8'd255, 2'd1, 8'd2},
        {8'd5,   8'd0, 8'd255, 2'd1, 8'd6},
        {8'd6,   8'd0, 8'd255, 2'd1, 8'd8},
        {8'd100, 8'd1, 8'd255, 2'd2, 8'd4},
        {8'd3,   8'd1, 8'd255, 2'd1, 8'd4},
        {8'd4,   8'd3, 8'd255, 2'd1, 8'd6},
        {8'd100, 8'd3, 8'd255, 2'd2, 8'd6},
        {8'd100, 8'd0, 8'd0,   2'd3, 8'd2},
        {8'd0,   8'd0, 8'd0,   2'd1, 8'd2},
        {8'd100, 8'd0, 8'd255, 2'd1, 8'd102},
        {8'd100, 8'd0, 8'd254, 2'd3, 8'd0},
        {8'd9,   8'd0, 8'd200, 2'd1, 8'd10}
    };

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic prep(input int t, input int f, input logic [TW-1:0] tmo,
                        input logic [AW-1:0] a);
        model_clr = 1'b1;
        step();
        step();
        model_clr = 1'b0;
        tog_n     = t;
        fail_at   = f;
        timeout   = tmo;
        poll_addr = a;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        step();
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (done) begin
                seen = 1'b1;
                break;
            end
            step();
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired, run hung");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit seen;
        logic [1:0] held;

        // R1: reset state
        step();
        chk(done == 1'b0, "R1 done after reset", done, 0);
        chk(result == 2'd0, "R1 result after reset", result, 0);
        chk(mem_ce_n && mem_oe_n, "R1 ce_n/oe_n after reset", {mem_ce_n, mem_oe_n}, 3);
        rst_n = 1'b1;
        step();

        // vector table
        for (int v = 0; v < NV; v++) begin
            prep(int'(VEC[v][33:26]), int'(VEC[v][25:18]), VEC[v][17:10], AW'(12'h100 + v));
            pulse_start();
            wait_done(seen);
            chk(seen, $sformatf("R3 R5 R6 R7 vector %0d done seen", v), seen, 1);
            chk(result == VEC[v][9:8],
                $sformatf("R3 R4 R5 R6 R7 vector %0d result", v), result, int'(VEC[v][9:8]));
            if (VEC[v][7:0] != 8'd0) begin
                chk(reads == int'(VEC[v][7:0]),
                    $sformatf("R2 R4 R5 vector %0d read count", v), reads, int'(VEC[v][7:0]));
            end else begin
                chk(reads % 2 == 0 && reads > 0,
                    $sformatf("R2 R6 vector %0d even read count", v), reads, 2);
            end
            held = result;
            step();
            chk(done == 1'b0, $sformatf("R9 vector %0d done one clock", v), done, 0);
            step();
            step();
            chk(result == held, $sformatf("R9 vector %0d result held", v), result, held);
        end

        // R2 and R10: read strobe shape, address, start ignored while busy
        prep(20, 0, 8'd255, 12'hABC);
        pulse_start();
        for (int i = 0; i < 20 && mem_oe_n; i++) step();
        chk(!mem_oe_n && !mem_ce_n, "R2 ce low during read", mem_ce_n, 0);
        chk(mem_addr == 12'hABC, "R2 read address", mem_addr, 12'hABC);
        step();
        chk(!mem_oe_n, "R2 oe low for second cycle", mem_oe_n, 0);
        step();
        chk(mem_oe_n, "R2 oe high gap after RD_CYC", mem_oe_n, 1);
        poll_addr = 12'h055;
        pulse_start();
        for (int i = 0; i < 20 && mem_oe_n; i++) step();
        chk(mem_addr == 12'hABC, "R10 address kept after busy start", mem_addr, 12'hABC);
        wait_done(seen);
        chk(seen && result == 2'd1, "R10 run completes normally", result, 1);
        chk(reads == 22, "R10 read count unaffected", reads, 22);

        // R8: ready/busy pin low, fallback wait
        prep(0, 0, 8'd255, 12'h321);
        rdy_i = 1'b0;
        pulse_start();
        step();
        step();
        chk(mem_oe_n && reads == 0, "R8 no read while waiting", reads, 0);
        wait_done(seen);
        chk(seen && result == 2'd1, "R8 completes after wait", result, 1);
        rdy_i = 1'b1;

        // R9: result cleared on next accepted start
        prep(30, 0, 8'd255, 12'h010);
        pulse_start();
        chk(result == 2'd0, "R9 result cleared on start", result, 0);
        wait_done(seen);
        chk(seen && result == 2'd1, "R9 result after restart", result, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule